// File: doc/BRIEF.md
# Colour-Keyed Dual-Stream Video Fader

The block blends two 4:2:2 Y/Cb/Cr pixel streams, a primary stream and a secondary stream, one sample pair per clock. Each beat carries one luma sample and one chroma sample on both inputs. A phase flag says whether the chroma lane holds Cb or Cr. A Cb beat and the Cr beat on the next clock form one co-sited group. For each group the block tests the primary pixel (the luma of the Cb beat, the Cb and the Cr) against two inclusive Y/U/V range windows. From that test it picks one of three 6-bit fade factors, and it decides whether the primary operand is replaced by a programmable lookup colour.

Static configuration inputs can force either operand to the lookup colour, or can switch keying off so that every pixel takes the lookup-colour path. An optional detector watches each input's luma for embedded timing codes. Code beats are never blended. Each start-of-active-video code toggles a pass-through state for its own input, and while that state is set the output is that input, unblended. The output keeps the phase flag of each beat and arrives a fixed three clocks after its input.

Top module: `ckey_fader`

## Requirements
- R1: While rst_n is low, and directly after it rises, out_valid, out_y and out_c are 0, whatever the inputs do.
- R2: A beat presented with in_valid high appears three rising edges later: out_valid is in_valid and out_cr is in_cr from three clocks earlier, with no earlier output.
- R3: Each blended lane gives ((63−F)·A + F·B + 31) / 63, where A is the primary-side operand and B the secondary-side operand. F = 0 returns A exactly and F = 63 returns B exactly.
- R4: key1_lo/key1_hi pack Y in bits [23:16], U (Cb) in [15:8] and V (Cr) in [7:0]. A group whose Y, Cb and Cr all lie inside the window, bounds included, is blended with fade_k1 against the secondary stream.
- R5: A group inside the key2 window (same packing) is blended with fade_k2. Its primary operand is replaced by lut_yuv (same packing): Y on the luma lane, U on Cb beats and V on Cr beats.
- R6: A group inside neither window is blended with fade_other, primary against secondary.
- R7: A group inside both windows is treated as a key1 group.
- R8: The Cb beat and the following Cr beat share one decision, made from the Cb beat's luma, its Cb and the Cr. The Cr beat's own luma plays no part in the decision.
- R9: With key_ignore high, every group takes the key2 path, whatever the windows hold.
- R10: pri_use_lut replaces the primary operand with the lookup colour for every group. sec_use_lut replaces the secondary operand with the lookup colour.
- R11: With code_en high, an input's luma sequence FFh, 00h, 00h, S on consecutive valid beats is a timing code. If bit 4 of S is 0 (start of active video), the pass state of that input toggles. While a pass state is set, both output lanes carry that input unchanged. The primary takes precedence when both are set.
- R12: With code_en high, each beat of a code (luma FFh and the three beats after it) is output unchanged: the primary's samples if the code is on the primary, otherwise the secondary's.
- R13: With code_en low, FFh and 00h are ordinary data and both pass states are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_cr | input | 1 | Chroma lane holds Cr (1) or Cb (0) |
| pri_y | input | 8 | Primary luma sample |
| pri_c | input | 8 | Primary chroma sample |
| sec_y | input | 8 | Secondary luma sample |
| sec_c | input | 8 | Secondary chroma sample |
| key1_lo | input | 24 | Key 1 lower bounds {Y,U,V} |
| key1_hi | input | 24 | Key 1 upper bounds {Y,U,V} |
| key2_lo | input | 24 | Key 2 lower bounds {Y,U,V} |
| key2_hi | input | 24 | Key 2 upper bounds {Y,U,V} |
| fade_k1 | input | 6 | Fade factor for key 1 groups |
| fade_k2 | input | 6 | Fade factor for key 2 groups |
| fade_other | input | 6 | Fade factor for unkeyed groups |
| lut_yuv | input | 24 | Lookup colour {Y,U,V} |
| key_ignore | input | 1 | Treat every group as key 2 |
| pri_use_lut | input | 1 | Force primary operand to lookup colour |
| sec_use_lut | input | 1 | Force secondary operand to lookup colour |
| code_en | input | 1 | Enable embedded timing-code detection |
| out_valid | output | 1 | Output beat present |
| out_cr | output | 1 | Chroma phase of output beat |
| out_y | output | 8 | Output luma |
| out_c | output | 8 | Output chroma |

## Verification
On every cycle the assertions check the three-clock valid and phase delay, and that the Cr beat keeps its Cb beat's decision. They also check key 1 priority when both windows hit, the exact endpoint results at F = 0 and F = 63, that a blend lies between its operands, and that a pass state changes only on a status beat or when detection is switched off. Only the bench scenarios can show the actual arithmetic at interior fade values, and that the inclusive bounds select the right factor and operand. The same holds for the lookup-colour substitutions and for the full code sequences that toggle pass-through and hand precedence to the primary.

// File: rtl/ckf_pkg.sv
package ckf_pkg;
  typedef enum logic [1:0] {
    CLS_KEY1  = 2'd0,
    CLS_KEY2  = 2'd1,
    CLS_OTHER = 2'd2
  } key_class_e;
endpackage

// File: rtl/ckf_window_match.sv
// Inclusive three-component range test on a packed {Y,U,V} pixel.
module ckf_window_match #(
  parameter int DW = 8
) (
  input  logic [3*DW-1:0] pix,
  input  logic [3*DW-1:0] lo,
  input  logic [3*DW-1:0] hi,
  output logic            hit
);
  localparam int NCOMP = 3;

  logic [NCOMP-1:0] comp_ok;

  for (genvar g = 0; g < NCOMP; g++) begin : g_comp
    always_comb begin
      comp_ok[g] = (pix[g*DW +: DW] >= lo[g*DW +: DW]) &&
                   (pix[g*DW +: DW] <= hi[g*DW +: DW]);
    end
  end

  assign hit = &comp_ok;
endmodule

// File: rtl/ckf_code_detect.sv
// Watches one luma stream for all-ones, zero, zero, status; toggles a pass
// flag on each start-of-active-video status word.
module ckf_code_detect #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          code_en,
  input  logic [DW-1:0] y,
  output logic          in_code,
  output logic          pass
);
  localparam logic [DW-1:0] ALL1  = {DW{1'b1}};
  localparam logic [DW-1:0] ALL0  = {DW{1'b0}};
  localparam int            H_BIT = DW - 4;

  logic [1:0] cnt_q, cnt_n;
  logic       pass_q, pass_n;

  always_comb begin
    cnt_n  = cnt_q;
    pass_n = pass_q;
    if (!code_en) begin
      cnt_n  = 2'd0;
      pass_n = 1'b0;
    end else if (en) begin
      case (cnt_q)
        2'd0: cnt_n = (y == ALL1) ? 2'd1 : 2'd0;
        2'd1: cnt_n = (y == ALL0) ? 2'd2 : ((y == ALL1) ? 2'd1 : 2'd0);
        2'd2: cnt_n = (y == ALL0) ? 2'd3 : ((y == ALL1) ? 2'd1 : 2'd0);
        default: begin
          cnt_n = 2'd0;
          if (!y[H_BIT]) pass_n = !pass_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 2'd0;
      pass_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pass_q <= pass_n;
    end
  end

  assign in_code = code_en && ((y == ALL1) || (cnt_q != 2'd0));
  assign pass    = pass_q;

  // R11: the pass flag moves only on a status beat or on disable
  p_pass_on_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pass_q) |-> (($past(cnt_q) == 2'd3) && $past(en)) || !$past(code_en));

  // R13: detection off leaves no pass state behind
  p_disabled_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !code_en |=> !pass_q);
endmodule

// File: rtl/ckf_mix_lane.sv
// One blend lane: rounded weighted mean with F/FMAX scaling, registered.
module ckf_mix_lane #(
  parameter int DW = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [FW-1:0] f,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          bypass,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] q
);
  localparam int PW   = DW + FW + 1;
  localparam int FMAX = (1 << FW) - 1;
  localparam int DMAX = (1 << DW) - 1;

  logic [PW-1:0] a_x, b_x, w_a, w_b, acc, quo;
  logic [DW-1:0] blend, q_n, q_r;

  always_comb begin
    a_x   = PW'(a);
    b_x   = PW'(b);
    w_b   = PW'(f);
    w_a   = PW'(FMAX) - w_b;
    acc   = w_a * a_x + w_b * b_x + PW'(FMAX / 2);
    quo   = acc / PW'(FMAX);
    blend = (quo > PW'(DMAX)) ? DW'(DMAX) : quo[DW-1:0];
    q_n   = bypass ? raw : blend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else if (en) q_r <= q_n;
  end

  assign q = q_r;

  // R3: endpoints are exact
  p_fade_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bypass && f == '0) |=> q_r == $past(a));
  p_fade_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bypass && f == FW'(FMAX)) |=> q_r == $past(b));
  // R3: a blend never leaves the span of its operands
  p_fade_between_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !bypass) |=> ((q_r >= $past(a)) || (q_r >= $past(b))) &&
                        ((q_r <= $past(a)) || (q_r <= $past(b))));
endmodule

// File: rtl/ckey_fader.sv
module ckey_fader #(
  parameter int DW = 8,
  parameter int FW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_cr,
  input  logic [DW-1:0]   pri_y,
  input  logic [DW-1:0]   pri_c,
  input  logic [DW-1:0]   sec_y,
  input  logic [DW-1:0]   sec_c,
  input  logic [3*DW-1:0] key1_lo,
  input  logic [3*DW-1:0] key1_hi,
  input  logic [3*DW-1:0] key2_lo,
  input  logic [3*DW-1:0] key2_hi,
  input  logic [FW-1:0]   fade_k1,
  input  logic [FW-1:0]   fade_k2,
  input  logic [FW-1:0]   fade_other,
  input  logic [3*DW-1:0] lut_yuv,
  input  logic            key_ignore,
  input  logic            pri_use_lut,
  input  logic            sec_use_lut,
  input  logic            code_en,
  output logic            out_valid,
  output logic            out_cr,
  output logic [DW-1:0]   out_y,
  output logic [DW-1:0]   out_c
);
  import ckf_pkg::*;

  localparam int PIXW  = 3 * DW;
  localparam int NSRC  = 2;   // 0 primary, 1 secondary
  localparam int NKEY  = 2;
  localparam int NLANE = 2;   // 0 luma, 1 chroma

  // ---------------- timing-code detectors, one per input ----------------
  logic [DW-1:0]   det_y [NSRC];
  logic [NSRC-1:0] det_code, det_pass;

  assign det_y[0] = pri_y;
  assign det_y[1] = sec_y;

  for (genvar s = 0; s < NSRC; s++) begin : g_det
    ckf_code_detect #(.DW(DW)) u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (in_valid),
      .code_en (code_en),
      .y       (det_y[s]),
      .in_code (det_code[s]),
      .pass    (det_pass[s])
    );
  end

  // ---------------- stage 1: input register ----------------
  logic            s1_vld, s1_cr;
  logic [DW-1:0]   s1_py, s1_pc, s1_sy, s1_sc;
  logic [NSRC-1:0] s1_code, s1_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_cr   <= 1'b0;
      s1_py   <= '0;
      s1_pc   <= '0;
      s1_sy   <= '0;
      s1_sc   <= '0;
      s1_code <= '0;
      s1_pass <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_cr   <= in_cr;
        s1_py   <= pri_y;
        s1_pc   <= pri_c;
        s1_sy   <= sec_y;
        s1_sc   <= sec_c;
        s1_code <= det_code;
        s1_pass <= det_pass;
      end
    end
  end

  // ---------------- key decision: Cb beat in stage 1, Cr at the input ----
  logic [PIXW-1:0] key_lo [NKEY];
  logic [PIXW-1:0] key_hi [NKEY];
  logic [PIXW-1:0] grp_yuv;
  logic [NKEY-1:0] key_hit;
  key_class_e      cls_new, cls_n, s2_cls;

  assign key_lo[0] = key1_lo;
  assign key_hi[0] = key1_hi;
  assign key_lo[1] = key2_lo;
  assign key_hi[1] = key2_hi;
  assign grp_yuv   = {s1_py, s1_pc, pri_c};

  for (genvar k = 0; k < NKEY; k++) begin : g_key
    ckf_window_match #(.DW(DW)) u_win (
      .pix (grp_yuv),
      .lo  (key_lo[k]),
      .hi  (key_hi[k]),
      .hit (key_hit[k])
    );
  end

  always_comb begin
    if (key_ignore)      cls_new = CLS_KEY2;
    else if (key_hit[0]) cls_new = CLS_KEY1;
    else if (key_hit[1]) cls_new = CLS_KEY2;
    else                 cls_new = CLS_OTHER;
    cls_n = s1_cr ? s2_cls : cls_new;
  end

  // ---------------- stage 2: decided beat ----------------
  logic            s2_vld, s2_cr;
  logic [DW-1:0]   s2_py, s2_pc, s2_sy, s2_sc;
  logic [NSRC-1:0] s2_code, s2_pass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_vld  <= 1'b0;
      s2_cr   <= 1'b0;
      s2_py   <= '0;
      s2_pc   <= '0;
      s2_sy   <= '0;
      s2_sc   <= '0;
      s2_code <= '0;
      s2_pass <= '0;
      s2_cls  <= CLS_OTHER;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_cr   <= s1_cr;
        s2_py   <= s1_py;
        s2_pc   <= s1_pc;
        s2_sy   <= s1_sy;
        s2_sc   <= s1_sc;
        s2_code <= s1_code;
        s2_pass <= s1_pass;
        s2_cls  <= cls_n;
      end
    end
  end

  // ---------------- operand and factor selection ----------------
  logic [DW-1:0] lut_y, lut_cs;
  logic [FW-1:0] f_sel;
  logic [DW-1:0] a_op [NLANE];
  logic [DW-1:0] b_op [NLANE];
  logic [DW-1:0] raw  [NLANE];
  logic [DW-1:0] lane_q [NLANE];
  logic          pri_lut_now, raw_pri, bypass;

  always_comb begin
    lut_y       = lut_yuv[3*DW-1:2*DW];
    lut_cs      = s2_cr ? lut_yuv[DW-1:0] : lut_yuv[2*DW-1:DW];
    case (s2_cls)
      CLS_KEY1: f_sel = fade_k1;
      CLS_KEY2: f_sel = fade_k2;
      default:  f_sel = fade_other;
    endcase
    pri_lut_now = (s2_cls == CLS_KEY2) || pri_use_lut;
    a_op[0]     = pri_lut_now ? lut_y  : s2_py;
    a_op[1]     = pri_lut_now ? lut_cs : s2_pc;
    b_op[0]     = sec_use_lut ? lut_y  : s2_sy;
    b_op[1]     = sec_use_lut ? lut_cs : s2_sc;
    raw_pri     = s2_code[0] || s2_pass[0];
    bypass      = raw_pri || s2_code[1] || s2_pass[1];
    raw[0]      = raw_pri ? s2_py : s2_sy;
    raw[1]      = raw_pri ? s2_pc : s2_sc;
  end

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    ckf_mix_lane #(.DW(DW), .FW(FW)) u_mix (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (s2_vld),
      .f      (f_sel),
      .a      (a_op[l]),
      .b      (b_op[l]),
      .bypass (bypass),
      .raw    (raw[l]),
      .q      (lane_q[l])
    );
  end

  // ---------------- stage 3: output framing ----------------
  logic o_vld, o_cr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_vld <= 1'b0;
      o_cr  <= 1'b0;
    end else begin
      o_vld <= s2_vld;
      if (s2_vld) o_cr <= s2_cr;
    end
  end

  assign out_valid = o_vld;
  assign out_cr    = o_cr;
  assign out_y     = lane_q[0];
  assign out_c     = lane_q[1];

  // ---------------- checks ----------------
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3) |-> out_valid == $past(in_valid, 3));
  p_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == 2'd3 && out_valid) |-> out_cr == $past(in_cr, 3));
  p_key1_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_cr && !key_ignore && key_hit[0] && key_hit[1]) |=> s2_cls == CLS_KEY1);
  p_pair_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_cr) |=> $stable(s2_cls));
  p_ignore_key2_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && !s1_cr && key_ignore) |=> s2_cls == CLS_KEY2);
endmodule

// File: tb/tb_ckey_fader.sv
`timescale 1ns/1ps
module tb_ckey_fader;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_cr;
  logic [7:0]  pri_y, pri_c, sec_y, sec_c;
  logic [23:0] key1_lo, key1_hi, key2_lo, key2_hi, lut_yuv;
  logic [5:0]  fade_k1, fade_k2, fade_other;
  logic        key_ignore, pri_use_lut, sec_use_lut, code_en;
  logic        out_valid, out_cr;
  logic [7:0]  out_y, out_c;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  ckey_fader dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cr(in_cr),
    .pri_y(pri_y), .pri_c(pri_c), .sec_y(sec_y), .sec_c(sec_c),
    .key1_lo(key1_lo), .key1_hi(key1_hi), .key2_lo(key2_lo), .key2_hi(key2_hi),
    .fade_k1(fade_k1), .fade_k2(fade_k2), .fade_other(fade_other),
    .lut_yuv(lut_yuv), .key_ignore(key_ignore), .pri_use_lut(pri_use_lut),
    .sec_use_lut(sec_use_lut), .code_en(code_en),
    .out_valid(out_valid), .out_cr(out_cr), .out_y(out_y), .out_c(out_c)
  );

  // {pri Cb, pri Y0, pri Cr, pri Y1, sec Cb, sec Y0, sec Cr, sec Y1}
  localparam logic [63:0] VEC [8] = '{
    64'h7878781E_3C5AC8DC,  // inside key 1, Y1 outside (R8)
    64'h64646407_0A141E28,  // key 1 lower bounds
    64'h969696FA_F0E6DCD2,  // key 1 upper bounds
    64'h78977878_30405060,  // Y one above key 1, Y1 inside (R8)
    64'hDC281E32_80808080,  // inside key 2
    64'hC83C3C5A_11223344,  // key 2 bounds
    64'h05FA05FA_90A0B0C0,  // neither window
    64'h63787878_70605040   // U one below key 1
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int mixv(input int a, input int b, input int f);
    return ((63 - f) * a + f * b + 31) / 63;
  endfunction

  function automatic bit inwin(input int y, input int u, input int v,
                               input logic [23:0] lo, input logic [23:0] hi);
    return (y >= lo[23:16] && y <= hi[23:16] && u >= lo[15:8] && u <= hi[15:8] &&
            v >= lo[7:0] && v <= hi[7:0]);
  endfunction

  // mode 0: blended, 1: primary unchanged, 2: secondary unchanged
  task automatic run_pair(input string tag, input logic [63:0] v, input int mode);
    int cls, f, ay, ac, by, bc, ey, ec, lc;
    int gy [2];
    int gc [2];
    int gv [2];
    int gp [2];
    string ctag;
    @(negedge clk);
    in_valid = 1'b1; in_cr = 1'b0;
    pri_c = v[63:56]; pri_y = v[55:48]; sec_c = v[31:24]; sec_y = v[23:16];
    @(negedge clk);
    in_cr = 1'b1;
    pri_c = v[47:40]; pri_y = v[39:32]; sec_c = v[15:8]; sec_y = v[7:0];
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R2 no early output"}, out_valid, 0);
    for (int b = 0; b < 2; b++) begin
      @(negedge clk);
      gy[b] = out_y; gc[b] = out_c; gv[b] = out_valid; gp[b] = out_cr;
    end
    if (key_ignore) cls = 1;
    else if (inwin(v[55:48], v[63:56], v[47:40], key1_lo, key1_hi)) cls = 0;
    else if (inwin(v[55:48], v[63:56], v[47:40], key2_lo, key2_hi)) cls = 1;
    else cls = 2;
    f    = (cls == 0) ? fade_k1 : (cls == 1) ? fade_k2 : fade_other;
    ctag = (cls == 0) ? "R4" : (cls == 1) ? "R5" : "R6";
    for (int b = 0; b < 2; b++) begin
      int py, pc, sy, sc;
      py = (b == 0) ? v[55:48] : v[39:32];
      pc = (b == 0) ? v[63:56] : v[47:40];
      sy = (b == 0) ? v[23:16] : v[7:0];
      sc = (b == 0) ? v[31:24] : v[15:8];
      lc = (b == 0) ? lut_yuv[15:8] : lut_yuv[7:0];
      ay = (cls == 1 || pri_use_lut) ? lut_yuv[23:16] : py;
      ac = (cls == 1 || pri_use_lut) ? lc : pc;
      by = sec_use_lut ? lut_yuv[23:16] : sy;
      bc = sec_use_lut ? lc : sc;
      ey = (mode == 1) ? py : (mode == 2) ? sy : mixv(ay, by, f);
      ec = (mode == 1) ? pc : (mode == 2) ? sc : mixv(ac, bc, f);
      chk($sformatf("%s R2 valid beat%0d", tag, b), gv[b], 1);
      chk($sformatf("%s R2 phase beat%0d", tag, b), gp[b], b);
      chk($sformatf("%s %s R8 luma beat%0d", tag, ctag, b), gy[b], ey);
      chk($sformatf("%s %s R8 chroma beat%0d", tag, ctag, b), gc[b], ec);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b1; in_cr = 1'b0;
    pri_y = 8'h55; pri_c = 8'h66; sec_y = 8'h77; sec_c = 8'h88;
    key1_lo = 24'h646464; key1_hi = 24'h969696;
    key2_lo = 24'h14C814; key2_hi = 24'h3CF03C;
    lut_yuv = 24'hC832B4;
    fade_k1 = 6'd10; fade_k2 = 6'd40; fade_other = 6'd25;
    key_ignore = 1'b0; pri_use_lut = 1'b0; sec_use_lut = 1'b0; code_en = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 valid in reset", out_valid, 0);
    chk("R1 luma in reset", out_y, 0);
    chk("R1 chroma in reset", out_c, 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", out_valid, 0);
    chk("R1 luma after reset", out_y, 0);
    chk("R1 chroma after reset", out_c, 0);

    // table walk: R4 R5 R6 R8
    for (int i = 0; i < 8; i++) run_pair($sformatf("vec%0d", i), VEC[i], 0);

    // R3 endpoints
    fade_other = 6'd0;  run_pair("R3 F=0", VEC[6], 0);
    fade_other = 6'd63; run_pair("R3 F=63", VEC[6], 0);
    fade_other = 6'd25;

    // R7 both windows hit
    key2_lo = 24'h000000; key2_hi = 24'hFFFFFF;
    run_pair("R7 overlap", VEC[0], 0);
    run_pair("R7 key2 only", VEC[6], 0);
    key2_lo = 24'h14C814; key2_hi = 24'h3CF03C;

    // R9
    key_ignore = 1'b1; run_pair("R9 ignore", VEC[0], 0); key_ignore = 1'b0;
    // R10
    pri_use_lut = 1'b1; run_pair("R10 primary lut", VEC[6], 0); pri_use_lut = 1'b0;
    sec_use_lut = 1'b1; run_pair("R10 secondary lut", VEC[0], 0); sec_use_lut = 1'b0;

    // R11 R12 timing codes
    code_en = 1'b1;
    run_pair("R12 pri code a", 64'h80FF8000_10203040, 1);
    run_pair("R12 pri SAV", 64'h80008080_10203040, 1);
    run_pair("R11 pri pass", VEC[6], 1);
    run_pair("R12 pri code b", 64'h80FF8000_50607080, 1);
    run_pair("R12 pri EAV", 64'h80008090_50607080, 1);
    run_pair("R11 EAV keeps pass", VEC[0], 1);
    run_pair("R12 pri code c", 64'h80FF8000_10203040, 1);
    run_pair("R12 pri SAV off", 64'h80008080_10203040, 1);
    run_pair("R11 pass off", VEC[6], 0);
    run_pair("R12 sec code", 64'h78787878_80FF8000, 2);
    run_pair("R12 sec SAV", 64'h78787878_80008080, 2);
    run_pair("R11 sec pass", VEC[6], 2);
    run_pair("R12 pri code d", 64'h80FF8000_10203040, 1);
    run_pair("R12 pri SAV on", 64'h80008080_10203040, 1);
    run_pair("R11 primary first", VEC[6], 1);

    // R13
    code_en = 1'b0;
    run_pair("R13 flags cleared", VEC[6], 0);
    run_pair("R13 code as data a", 64'h80FF8000_10203040, 0);
    run_pair("R13 code as data b", 64'h80008080_10203040, 0);
    run_pair("R13 no pass", VEC[0], 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule